// File: doc/BRIEF.md
# Nanosecond Time Counter with Capture

This block keeps a running nanosecond time value for a precision-time subsystem. On every edge of its timer clock the counter grows by a programmable step. The step is the timer clock period in whole nanoseconds: 8 for a 125 MHz clock, 20 for 50 MHz and 25 for 40 MHz. In seconds mode the value rolls over at one billion nanoseconds. The amount past the limit is kept, so no time is lost at the rollover. In free mode the value simply rolls over at 2^32. The step, the mode and a direct load of the counter are all controlled from the timer domain.

There are two ways to take a snapshot. An external event pin is synchronized into the timer domain, and each rising edge latches the counter and raises a sticky event interrupt flag. This still works when the edge lands on the rollover cycle. Software in a separate peripheral clock domain can also pulse a capture request. The request crosses to the timer domain as a toggle, the counter value is taken there, and the acknowledge toggle comes back. Software polls a done bit, and the readout register changes only when that bit rises. A second sticky flag marks each seconds rollover.

Top module: `ns_time_counter`

## Requirements
- R1: While `rstN` is low, `timeNow`, `evtTime`, `capTime`, `evtIrq`, `wrapIrq` and `capDone` are all zero. The step register resets to 8.
- R2: On each `tmrClk` edge without a load, the counter adds the step. A step written with `incWr` (7 bits, `incData`) is used from the next timer edge on.
- R3: When `modeSec` is 1 and counter plus step is at least 1,000,000,000, the counter becomes that sum minus 1,000,000,000.
- R4: When `modeSec` is 0, the counter wraps modulo 2^32 and `wrapIrq` is never set by that wrap.
- R5: A seconds-mode rollover sets `wrapIrq`.
- R6: `loadWr` places `loadData` in the counter on that timer edge, with priority over the step.
- R7: `evtIn` passes through two timer-domain flops. Its rising edge sets `evtIrq` and copies into `evtTime` the counter value of the cycle before the flag rises, which is the third timer edge after the pin goes high. A level held high does not capture again.
- R8: An event edge on the same timer edge as a seconds rollover still sets `evtIrq`.
- R9: After a `capReq` pulse is accepted on a `busClk` edge, `capDone` goes low and rises no sooner than 6 `busClk` edges later. Until it rises, `capTime` keeps the previous snapshot.
- R10: The `capTime` value is a counter value taken between the request and the rise of `capDone`.
- R11: A `capReq` pulse while a capture is in flight is ignored. It neither restarts nor clears the done bit later.
- R12: `evtIrq` and `wrapIrq` stay set until a 1 is written to `evtIrqClr` or `wrapIrqClr`. A new set on the same edge as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tmrClk | input | 1 | Timer clock |
| busClk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| modeSec | input | 1 | 1 = roll over at 1e9 ns, 0 = roll over at 2^32 (timer domain) |
| incWr | input | 1 | Step write strobe (timer domain) |
| incData | input | 7 | New step in ns |
| loadWr | input | 1 | Counter load strobe (timer domain) |
| loadData | input | 32 | Value to load |
| evtIn | input | 1 | Asynchronous external event pin |
| evtIrqClr | input | 1 | Write-1 clear of the event flag (timer domain) |
| wrapIrqClr | input | 1 | Write-1 clear of the rollover flag (timer domain) |
| timeNow | output | 32 | Live counter value |
| evtTime | output | 32 | Counter value latched by the last event |
| evtIrq | output | 1 | Sticky event interrupt flag |
| wrapIrq | output | 1 | Sticky rollover interrupt flag |
| capReq | input | 1 | One-cycle software capture request (peripheral domain) |
| capDone | output | 1 | Software capture complete (peripheral domain) |
| capTime | output | 32 | Software readout register (peripheral domain) |

## Verification
A load appears on `timeNow` right after the timer edge that takes it. A new step first shows one edge later. The bench therefore samples on the falling timer edge after exactly the counted number of rising edges. The event flag and `evtTime` are due on the third timer edge after the pin rises, and the bench places that edge on a rollover so that both flags can be checked in the same sample. A software capture completes between 6 and about 10 peripheral cycles after the request, depending on clock phase. The bench polls `capDone` once per peripheral cycle, on the falling edge. It checks the lower bound and an upper bound of 12, and confirms that `capTime` held its old value while it waited.

// File: rtl/nstc_pkg.sv
package nstc_pkg;

  // strobes from the control unit to the counter datapath (timer domain)
  typedef struct packed {
    logic incWe;    // take a new step value
    logic loadWe;   // overwrite the counter
    logic evtStb;   // external event edge: latch counter
    logic snapStb;  // software request arrived: latch counter
  } dpStrobe_t;

endpackage

// File: rtl/nstc_sync.sv
module nstc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ff <= '0;
        else       ff <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ff <= '0;
        else       ff <= {ff[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff[STAGES-1];

endmodule

// File: rtl/nstc_datapath.sv
module nstc_datapath
  import nstc_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned INC_W     = 7,
  parameter int unsigned PERIOD_NS = 1_000_000_000,
  parameter int unsigned INC_RESET = 8
) (
  input  logic             tmrClk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic             modeSec,
  input  logic [INC_W-1:0] incData,
  input  logic [CNT_W-1:0] loadData,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] evtTime,
  output logic [CNT_W-1:0] snapTime,
  output logic             wrapStb
);

  localparam int unsigned       SUM_W = CNT_W + 1;
  localparam logic [SUM_W-1:0]  LIMIT = SUM_W'(PERIOD_NS);
  localparam logic [CNT_W-1:0]  LIM_C = CNT_W'(PERIOD_NS);

  logic [INC_W-1:0] incReg;
  logic [SUM_W-1:0] sum;
  logic             overLim;
  logic [CNT_W-1:0] nextCnt;

  always_comb begin
    sum     = {1'b0, cnt} + SUM_W'(incReg);
    overLim = modeSec && (sum >= LIMIT);
    nextCnt = overLim ? CNT_W'(sum - LIMIT) : sum[CNT_W-1:0];
    wrapStb = overLim && !stb.loadWe;
  end

  always_ff @(posedge tmrClk or negedge rstN) begin
    if (!rstN) begin
      incReg   <= INC_W'(INC_RESET);
      cnt      <= '0;
      evtTime  <= '0;
      snapTime <= '0;
    end else begin
      if (stb.incWe) incReg <= incData;
      cnt <= stb.loadWe ? loadData : nextCnt;
      if (stb.evtStb)  evtTime  <= cnt;
      if (stb.snapStb) snapTime <= cnt;
    end
  end

  logic live;
  always_ff @(posedge tmrClk or negedge rstN) begin
    if (!rstN) live <= 1'b0;
    else       live <= 1'b1;
  end

  // R3: in seconds mode a value below the limit never steps past it
  p_periodic_bound_r3: assert property (@(posedge tmrClk) disable iff (!rstN)
    (live && modeSec && !stb.loadWe && cnt < LIM_C) |=> (cnt < LIM_C));

  // R4: free mode is a plain modulo-2^CNT_W step
  p_free_step_r4: assert property (@(posedge tmrClk) disable iff (!rstN)
    (live && !modeSec && !stb.loadWe) |=> (cnt == $past(cnt) + CNT_W'($past(incReg))));

  // R6: a load lands on the next edge regardless of the step
  p_load_r6: assert property (@(posedge tmrClk) disable iff (!rstN)
    (live && stb.loadWe) |=> (cnt == $past(loadData)));

endmodule

// File: rtl/nstc_control.sv
module nstc_control
  import nstc_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned MIN_LAT = 6,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic             tmrClk,
  input  logic             busClk,
  input  logic             rstN,
  input  logic             incWr,
  input  logic             loadWr,
  input  logic             evtIn,
  input  logic             evtClr,
  input  logic             wrapClr,
  input  logic             wrapStb,
  input  logic [CNT_W-1:0] snapTime,
  input  logic             capReq,
  output dpStrobe_t        stb,
  output logic             evtIrq,
  output logic             wrapIrq,
  output logic             capDone,
  output logic [CNT_W-1:0] capTime
);

  localparam int unsigned     AGE_W   = (MIN_LAT > 2) ? $clog2(MIN_LAT) : 1;
  localparam logic [AGE_W-1:0] AGE_TOP = AGE_W'(MIN_LAT - 1);

  // ---------------- timer domain ----------------
  logic evtS, evtPrev, reqS, reqSeen, tLive;

  nstc_sync #(.STAGES(SYNC_N)) u_evtSync (.clk(tmrClk), .rstN(rstN), .d(evtIn), .q(evtS));

  logic reqTgl;
  nstc_sync #(.STAGES(SYNC_N)) u_reqSync (.clk(tmrClk), .rstN(rstN), .d(reqTgl), .q(reqS));

  always_comb begin
    stb.incWe   = incWr;
    stb.loadWe  = loadWr;
    stb.evtStb  = evtS & ~evtPrev;
    stb.snapStb = reqS ^ reqSeen;
  end

  always_ff @(posedge tmrClk or negedge rstN) begin
    if (!rstN) begin
      evtPrev <= 1'b0;
      reqSeen <= 1'b0;
      evtIrq  <= 1'b0;
      wrapIrq <= 1'b0;
      tLive   <= 1'b0;
    end else begin
      evtPrev <= evtS;
      reqSeen <= reqS;  // doubles as the acknowledge toggle
      evtIrq  <= stb.evtStb | (evtIrq & ~evtClr);
      wrapIrq <= wrapStb    | (wrapIrq & ~wrapClr);
      tLive   <= 1'b1;
    end
  end

  // ---------------- peripheral domain ----------------
  logic             ackS, pending, bLive;
  logic [AGE_W-1:0] age;

  nstc_sync #(.STAGES(SYNC_N)) u_ackSync (.clk(busClk), .rstN(rstN), .d(reqSeen), .q(ackS));

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      reqTgl  <= 1'b0;
      pending <= 1'b0;
      age     <= '0;
      capDone <= 1'b0;
      capTime <= '0;
      bLive   <= 1'b0;
    end else begin
      bLive <= 1'b1;
      if (capReq && !pending) begin
        reqTgl  <= ~reqTgl;
        pending <= 1'b1;
        capDone <= 1'b0;
        age     <= '0;
      end else if (pending) begin
        if (age != AGE_TOP) age <= age + 1'b1;
        if (ackS == reqTgl && age == AGE_TOP) begin
          capTime <= snapTime;
          capDone <= 1'b1;
          pending <= 1'b0;
        end
      end
    end
  end

  // R8: an event edge always raises its flag, rollover or clear notwithstanding
  p_evt_set_r8: assert property (@(posedge tmrClk) disable iff (!rstN)
    (tLive && stb.evtStb) |=> evtIrq);

  // R12: flags hold until cleared
  p_evt_hold_r12: assert property (@(posedge tmrClk) disable iff (!rstN)
    (tLive && evtIrq && !evtClr) |=> evtIrq);

  // R5: each seconds rollover leaves the wrap flag set
  p_wrap_set_r5: assert property (@(posedge tmrClk) disable iff (!rstN)
    (tLive && wrapStb) |=> wrapIrq);

  // R9: readout register only moves when completion rises
  p_cap_hold_r9: assert property (@(posedge busClk) disable iff (!rstN)
    (bLive && !capDone) |=> ($stable(capTime) || capDone));

  // R9: no completion inside the minimum window
  p_min_lat_r9: assert property (@(posedge busClk) disable iff (!rstN)
    (bLive && pending && age != AGE_TOP) |=> !capDone);

  // R11: a request during a capture does not toggle the crossing
  p_ignore_r11: assert property (@(posedge busClk) disable iff (!rstN)
    (bLive && pending && capReq) |=> $stable(reqTgl));

endmodule

// File: rtl/ns_time_counter.sv
module ns_time_counter
  import nstc_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned INC_W     = 7,
  parameter int unsigned PERIOD_NS = 1_000_000_000,
  parameter int unsigned INC_RESET = 8,
  parameter int unsigned MIN_LAT   = 6,
  parameter int unsigned SYNC_N    = 2
) (
  input  logic             tmrClk,
  input  logic             busClk,
  input  logic             rstN,
  input  logic             modeSec,
  input  logic             incWr,
  input  logic [INC_W-1:0] incData,
  input  logic             loadWr,
  input  logic [CNT_W-1:0] loadData,
  input  logic             evtIn,
  input  logic             evtIrqClr,
  input  logic             wrapIrqClr,
  output logic [CNT_W-1:0] timeNow,
  output logic [CNT_W-1:0] evtTime,
  output logic             evtIrq,
  output logic             wrapIrq,
  input  logic             capReq,
  output logic             capDone,
  output logic [CNT_W-1:0] capTime
);

  dpStrobe_t        stb;
  logic             wrapStb;
  logic [CNT_W-1:0] snapTime;

  nstc_control #(
    .CNT_W(CNT_W), .MIN_LAT(MIN_LAT), .SYNC_N(SYNC_N)
  ) u_ctrl (
    .tmrClk(tmrClk), .busClk(busClk), .rstN(rstN),
    .incWr(incWr), .loadWr(loadWr), .evtIn(evtIn),
    .evtClr(evtIrqClr), .wrapClr(wrapIrqClr), .wrapStb(wrapStb),
    .snapTime(snapTime), .capReq(capReq), .stb(stb),
    .evtIrq(evtIrq), .wrapIrq(wrapIrq), .capDone(capDone), .capTime(capTime)
  );

  nstc_datapath #(
    .CNT_W(CNT_W), .INC_W(INC_W), .PERIOD_NS(PERIOD_NS), .INC_RESET(INC_RESET)
  ) u_dp (
    .tmrClk(tmrClk), .rstN(rstN), .stb(stb), .modeSec(modeSec),
    .incData(incData), .loadData(loadData), .cnt(timeNow),
    .evtTime(evtTime), .snapTime(snapTime), .wrapStb(wrapStb)
  );

endmodule

// File: tb/ns_time_counter_tb.sv
module ns_time_counter_tb_top;

  logic        tmrClk = 1'b0, busClk = 1'b0, rstN = 1'b0;
  logic        modeSec = 1'b1, incWr = 1'b0, loadWr = 1'b0, evtIn = 1'b0;
  logic        evtIrqClr = 1'b0, wrapIrqClr = 1'b0, capReq = 1'b0;
  logic [6:0]  incData = '0;
  logic [31:0] loadData = '0;
  logic [31:0] timeNow, evtTime, capTime;
  logic        evtIrq, wrapIrq, capDone;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2 busClk = ~busClk;            // 250 MHz peripheral clock
  initial begin #1; forever #4 tmrClk = ~tmrClk; end  // 125 MHz timer clock, offset

  ns_time_counter dut_i (
    .tmrClk(tmrClk), .busClk(busClk), .rstN(rstN), .modeSec(modeSec),
    .incWr(incWr), .incData(incData), .loadWr(loadWr), .loadData(loadData),
    .evtIn(evtIn), .evtIrqClr(evtIrqClr), .wrapIrqClr(wrapIrqClr),
    .timeNow(timeNow), .evtTime(evtTime), .evtIrq(evtIrq), .wrapIrq(wrapIrq),
    .capReq(capReq), .capDone(capDone), .capTime(capTime)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        mode;
    logic [31:0] load;
    logic [6:0]  inc;
    logic [7:0]  steps;
    logic [31:0] expCnt;
    logic        expWrap;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'd0,          7'd8,   8'd10, 32'd80,         1'b0},
    '{1'b1, 32'd999999990,  7'd8,   8'd2,  32'd6,          1'b1},
    '{1'b1, 32'd999999980,  7'd20,  8'd1,  32'd0,          1'b1},
    '{1'b1, 32'd999999999,  7'd25,  8'd3,  32'd74,         1'b1},
    '{1'b0, 32'hFFFF_FFF0,  7'd25,  8'd1,  32'd9,          1'b0},
    '{1'b0, 32'd999999990,  7'd20,  8'd1,  32'd1000000010, 1'b0},
    '{1'b1, 32'd123,        7'd127, 8'd4,  32'd631,        1'b0}
  };

  // load + step write + wrap-flag clear on one timer edge
  task automatic tmrLoad(input logic m, input logic [31:0] v, input logic [6:0] s);
    @(negedge tmrClk);
    modeSec = m; loadWr = 1'b1; loadData = v; incWr = 1'b1; incData = s; wrapIrqClr = 1'b1;
    @(posedge tmrClk);
    @(negedge tmrClk);
    loadWr = 1'b0; incWr = 1'b0; wrapIrqClr = 1'b0;
  endtask

  task automatic busPulse();
    @(negedge busClk); capReq = 1'b1;
    @(posedge busClk);
    @(negedge busClk); capReq = 1'b0;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [31:0] lo, hi, cap1, cap2;

    #15;
    // R1: reset state
    chk(timeNow == 0, "R1 timeNow", timeNow, 0);
    chk(evtIrq == 0 && wrapIrq == 0, "R1 flags", {evtIrq, wrapIrq}, 0);
    chk(capDone == 0 && capTime == 0 && evtTime == 0, "R1 capture regs", capTime, 0);
    #4 rstN = 1'b1;   // t=19, away from both clocks' edges

    // vector table: R2, R3, R4, R5, R6
    for (int i = 0; i < NV; i++) begin
      modeSec = VECS[i].mode;
      tmrLoad(VECS[i].mode, VECS[i].load, VECS[i].inc);
      chk(timeNow == VECS[i].load, "R6 load value", timeNow, VECS[i].load);
      for (int k = 0; k < int'(VECS[i].steps); k++) @(posedge tmrClk);
      @(negedge tmrClk);
      chk(timeNow == VECS[i].expCnt, VECS[i].mode ? "R2,R3 count" : "R2,R4 count",
          timeNow, VECS[i].expCnt);
      chk(wrapIrq == VECS[i].expWrap, VECS[i].mode ? "R5 wrap flag" : "R4 no wrap flag",
          wrapIrq, VECS[i].expWrap);
    end

    // R8: event edge lands on the rollover edge
    @(negedge tmrClk);
    evtIrqClr = 1'b1; modeSec = 1'b1; loadWr = 1'b1; loadData = 32'd999999984;
    incWr = 1'b1; incData = 7'd8; wrapIrqClr = 1'b1; evtIn = 1'b1;
    @(posedge tmrClk);                   // edge e: load, pin sampled
    @(negedge tmrClk);
    loadWr = 1'b0; incWr = 1'b0; wrapIrqClr = 1'b0; evtIrqClr = 1'b0;
    @(posedge tmrClk);                   // e+1
    @(negedge tmrClk);
    chk(evtIrq == 0, "R7 flag not yet due", evtIrq, 0);
    @(posedge tmrClk);                   // e+2: rollover and event together
    @(negedge tmrClk);
    chk(evtIrq == 1, "R8 event flag on rollover", evtIrq, 1);
    chk(wrapIrq == 1, "R5 rollover flag with event", wrapIrq, 1);
    chk(evtTime == 32'd999999992, "R7 event time", evtTime, 999999992);
    chk(timeNow == 0, "R3 exact limit", timeNow, 0);

    // R12: clear, and set beats clear
    evtIrqClr = 1'b1;
    @(posedge tmrClk); @(negedge tmrClk);
    evtIrqClr = 1'b0;
    chk(evtIrq == 0, "R12 event clear", evtIrq, 0);
    repeat (5) @(posedge tmrClk);
    @(negedge tmrClk);
    chk(evtIrq == 0, "R7 held level no recapture", evtIrq, 0);
    evtIn = 1'b0;

    tmrLoad(1'b1, 32'd999999992, 7'd8);
    wrapIrqClr = 1'b1;                   // clear on the rollover edge
    @(posedge tmrClk); @(negedge tmrClk);
    wrapIrqClr = 1'b0;
    chk(wrapIrq == 1, "R12 set wins over clear", wrapIrq, 1);
    wrapIrqClr = 1'b1;
    @(posedge tmrClk); @(negedge tmrClk);
    wrapIrqClr = 1'b0;
    chk(wrapIrq == 0, "R12 wrap clear", wrapIrq, 0);

    // R9, R10: software capture in free mode
    tmrLoad(1'b0, 32'd0, 7'd8);
    busPulse();
    lo = timeNow;
    n = 0;
    while (!capDone && n < 20) begin
      chk(capTime == 0, "R9 old value while waiting", capTime, 0);
      @(posedge busClk); @(negedge busClk); n++;
    end
    hi = timeNow;
    cap1 = capTime;
    chk(n >= 6, "R9 minimum latency", n, 6);
    chk(n <= 12, "R9 completes", n, 12);
    chk(cap1 >= lo && cap1 <= hi, "R10 snapshot window", cap1, lo);
    chk(cap1 % 8 == 0, "R10 snapshot on step grid", cap1 % 8, 0);

    // R11: new request clears done; a request in flight is ignored
    busPulse();
    chk(capDone == 0, "R11 done cleared by request", capDone, 0);
    chk(capTime == cap1, "R9 previous snapshot kept", capTime, cap1);
    @(posedge busClk);
    busPulse();                          // arrives while pending
    n = 0;
    while (!capDone && n < 20) begin
      @(posedge busClk); @(negedge busClk); n++;
    end
    cap2 = capTime;
    chk(capDone == 1, "R9 second capture done", capDone, 1);
    chk(cap2 > cap1, "R10 second snapshot later", cap2, cap1);
    repeat (20) @(posedge busClk);
    @(negedge busClk);
    chk(capDone == 1 && capTime == cap2, "R11 in-flight request ignored", capTime, cap2);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule